// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block holds the tag and valid bits for a 4-way set-associative cache with 16 KB of data in 32-byte lines. That is 512 lines arranged as 128 sets. The quoted capacity covers data only; the tag and valid storage kept here comes on top of it. Each entry stores just its 20-bit tag and a valid bit. The set index and the byte offset follow from where the entry sits, so they are never stored.

A lookup takes a 32-bit byte address and cuts it into three fields: tag, set and offset. It reads all four ways of the selected set and compares every valid way with the address tag in parallel. One cycle later it reports hit or miss, a one-hot vector of the hitting way, the decoded fields, and an error flag. The error flag rises when more than one valid way holds the same tag, since a set must never contain duplicates.

A separate fill port writes a tag into a chosen set and way and marks that entry valid. Choosing the victim, holding the line data, write handling and refill traffic are all left to the surrounding logic.

Top module: `tag_dir_top`

## Requirements
- R1: A synchronous active-low reset clears every valid bit and drives rsp_valid low. Every lookup after reset misses until a line is filled.
- R2: The address splits as offset = addr[4:0], set = addr[11:5] and tag = addr[31:12], reported on rsp_offset, rsp_set and rsp_tag. Address 0x200356A4 gives tag 0x20035, set 53 and offset 4.
- R3: rsp_valid is high in exactly the cycle after a cycle in which lk_valid was sampled high, and low otherwise.
- R4: A lookup hits (rsp_hit=1) when exactly one valid way of the set holds the address tag. rsp_way is then one-hot, with bit w standing for way w.
- R5: A lookup with no valid matching way misses: rsp_hit=0, rsp_way=0, rsp_multi=0.
- R6: A fill (fill_en high with fill_set, fill_way, fill_tag) writes the tag and sets valid in one clock edge. A lookup issued in the next cycle sees the new entry, and a fill over a valid entry replaces its old tag.
- R7: When a fill and a lookup to the same set are sampled on the same edge, the lookup reports the contents from before the fill.
- R8: When two or more valid ways of the set match, rsp_multi=1, rsp_hit=0 and rsp_way=0.
- R9: A fill changes only its own set and way. Entries in other ways and other sets keep hitting as before.
- R10: While rsp_valid is low, rsp_hit and rsp_multi are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Lookup byte address |
| fill_en | input | 1 | Fill write strobe |
| fill_set | input | 7 | Set written by the fill |
| fill_way | input | 2 | Way written by the fill |
| fill_tag | input | 20 | Tag written by the fill |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Exactly one valid way matched |
| rsp_way | output | 4 | One-hot hitting way, zero on miss or multi-match |
| rsp_multi | output | 1 | Several valid ways matched (broken invariant) |
| rsp_tag | output | 20 | Tag field of the looked-up address |
| rsp_set | output | 7 | Set field of the looked-up address |
| rsp_offset | output | 5 | Offset field of the looked-up address |

## Verification
Every lookup result is due one clock edge after the request is sampled. A fill takes effect on the edge that samples it, so a lookup issued in the following cycle already sees the new entry. The bench drives each input on a falling edge and then waits through exactly one rising edge. It reads the outputs at the next falling edge, which is the cycle in which they are valid. One falling edge later it checks that rsp_valid has dropped. For the same-cycle case, the bench drives the fill and the lookup on one falling edge and expects the old contents. It then issues a second lookup and expects the new entry.

// File: rtl/tag_dir_pkg.sv
// Package: tag_dir_pkg
// Geometry and shared types for the tag directory. Every width the rest of
// the design uses is derived here from the capacity, line size and way count.
package tag_dir_pkg;
    localparam int ADDR_W     = 32;
    localparam int CAP_BYTES  = 16384;
    localparam int LINE_BYTES = 32;
    localparam int WAYS       = 4;

    localparam int LINES  = CAP_BYTES / LINE_BYTES;
    localparam int SETS   = LINES / WAYS;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [WAYS-1:0]   wayvec_t;

    typedef struct packed {
        tag_t tag;
        set_t set;
        off_t off;
    } addr_fields_t;
endpackage

// File: rtl/tag_dir_split.sv
// Module: tag_dir_split
// Cuts a byte address into tag, set and offset. Purely combinational.
// Assumes the address layout tag | set | offset, with the offset in the low bits.
module tag_dir_split
    import tag_dir_pkg::*;
(
    input  addr_t        addr,
    output addr_fields_t fields
);
    // Field extraction by position.
    always_comb begin
        fields.off = addr[OFF_W-1:0];
        fields.set = addr[OFF_W +: SET_W];
        fields.tag = addr[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/tag_dir_array.sv
// Module: tag_dir_array
// Storage for the valid bits and tags of every set and way. Has one write port
// (the fill) and one combinational read port that returns a whole set.
// Assumes the caller registers the read data on the same edge that may write,
// so a read in that cycle returns the contents from before the write.
module tag_dir_array
    import tag_dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  set_t              wr_set,
    input  way_t              wr_way,
    input  tag_t              wr_tag,
    input  set_t              rd_set,
    output wayvec_t           rd_valid,
    output tag_t [WAYS-1:0]   rd_tags
);
    logic valid_q [SETS][WAYS];
    tag_t tag_q   [SETS][WAYS];

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                end
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag storage: written by a fill, not reset (gated by valid).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    // Read port: one set, all ways.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_valid[w] = valid_q[rd_set][w];
        assign rd_tags[w]  = tag_q[rd_set][w];
    end

    // R6: a fill leaves its entry valid after the edge.
    p_fill_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/tag_dir_match.sv
// Module: tag_dir_match
// Compares a request tag with every way of one set in parallel and classifies
// the result as hit (exactly one valid match), miss (none) or multi (several).
// Assumes the inputs are stable for the whole cycle (they come from registers).
module tag_dir_match
    import tag_dir_pkg::*;
(
    input  tag_t              req_tag,
    input  wayvec_t           way_valid,
    input  tag_t [WAYS-1:0]   way_tags,
    output wayvec_t           match,
    output logic              hit,
    output logic              multi
);
    localparam int CNT_W = $clog2(WAYS + 1);
    logic [CNT_W-1:0] n_match;

    // One comparator per way; an invalid way never matches.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w] == req_tag);
    end

    // Count the matches and classify them.
    always_comb begin
        n_match = '0;
        for (int w = 0; w < WAYS; w++) begin
            n_match = n_match + CNT_W'(match[w]);
        end
        hit   = (n_match == CNT_W'(1));
        multi = (n_match > CNT_W'(1));
    end
endmodule

// File: rtl/tag_dir_top.sv
// Module: tag_dir_top
// Tag directory for a 4-way set-associative cache. A lookup is sampled on one
// edge together with the addressed set's tags and valid bits; the compare runs
// in the following cycle, when the result is presented. Fills write in one edge.
// Assumes at most one fill and one lookup per cycle; fill way/set are in range.
module tag_dir_top
    import tag_dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAYS-1:0]   rsp_way,
    output logic              rsp_multi,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [SET_W-1:0]  rsp_set,
    output logic [OFF_W-1:0]  rsp_offset
);
    addr_fields_t    fld;
    wayvec_t         rd_valid;
    tag_t [WAYS-1:0] rd_tags;

    logic            vld_q;
    addr_fields_t    fld_q;
    wayvec_t         snap_valid_q;
    tag_t [WAYS-1:0] snap_tags_q;

    wayvec_t         match;
    logic            hit;
    logic            multi;

    tag_dir_split u_split (
        .addr   (lk_addr),
        .fields (fld)
    );

    tag_dir_array u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_en),
        .wr_set   (fill_set),
        .wr_way   (fill_way),
        .wr_tag   (fill_tag),
        .rd_set   (fld.set),
        .rd_valid (rd_valid),
        .rd_tags  (rd_tags)
    );

    // Response strobe: one cycle after each sampled request.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= lk_valid;
    end

    // Request snapshot: fields plus the set contents from before any same-edge fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q        <= '0;
            snap_valid_q <= '0;
            snap_tags_q  <= '0;
        end else if (lk_valid) begin
            fld_q        <= fld;
            snap_valid_q <= rd_valid;
            snap_tags_q  <= rd_tags;
        end
    end

    tag_dir_match u_match (
        .req_tag   (fld_q.tag),
        .way_valid (snap_valid_q),
        .way_tags  (snap_tags_q),
        .match     (match),
        .hit       (hit),
        .multi     (multi)
    );

    // Output qualification.
    always_comb begin
        rsp_valid  = vld_q;
        rsp_hit    = vld_q && hit;
        rsp_multi  = vld_q && multi;
        rsp_way    = rsp_hit ? match : '0;
        rsp_tag    = fld_q.tag;
        rsp_set    = fld_q.set;
        rsp_offset = fld_q.off;
    end

    // R4: a hit names exactly one way.
    p_hit_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $onehot(rsp_way));
    // R5: a miss names no way.
    p_miss_noway_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0));
    // R8: a multi-match is never reported as a hit.
    p_multi_not_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> (!rsp_hit && $countones(match) > 1));
    // R10: quiet outputs without a response.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_multi));
    // R3: a sampled request yields a response next cycle.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
endmodule

// File: tb/tag_dir_top_test.sv
module tag_dir_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        fill_en;
    logic [6:0]  fill_set;
    logic [1:0]  fill_way;
    logic [19:0] fill_tag;
    logic        rsp_valid, rsp_hit, rsp_multi;
    logic [3:0]  rsp_way;
    logic [19:0] rsp_tag;
    logic [6:0]  rsp_set;
    logic [4:0]  rsp_offset;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tag_dir_top uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_multi(rsp_multi), .rsp_tag(rsp_tag),
        .rsp_set(rsp_set), .rsp_offset(rsp_offset)
    );

    function automatic logic [31:0] mk(input logic [19:0] t, input logic [6:0] s,
                                       input logic [4:0] o);
        return {t, s, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Issue one lookup; on return the response cycle is being sampled.
    task automatic lookup(input logic [31:0] a);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [6:0] s, input logic [1:0] w, input logic [19:0] t);
        fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t;
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic hit,
                                 input logic [3:0] way, input logic multi);
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " hit"},   32'(rsp_hit),   32'(hit));
        chk({req, " way"},   32'(rsp_way),   32'(way));
        chk({req, " multi"}, 32'(rsp_multi), 32'(multi));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R10 hit quiet", 32'(rsp_hit), 0);
        lookup(32'h200356A4);
        expect_result("R1 empty lookup", 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_decode();
        lookup(32'h200356A4);
        chk("R2 tag",    32'(rsp_tag),    32'h20035);
        chk("R2 set",    32'(rsp_set),    32'd53);
        chk("R2 offset", 32'(rsp_offset), 32'd4);
        lookup(32'hFFFFFFFF);
        chk("R2 tag max",    32'(rsp_tag),    32'hFFFFF);
        chk("R2 set max",    32'(rsp_set),    32'd127);
        chk("R2 offset max", 32'(rsp_offset), 32'd31);
    endtask

    task automatic t_latency();
        lookup(32'h0);
        chk("R3 valid in response cycle", 32'(rsp_valid), 1);
        @(negedge clk);
        chk("R3 valid drops", 32'(rsp_valid), 0);
        chk("R10 hit low idle", 32'(rsp_hit), 0);
        chk("R10 multi low idle", 32'(rsp_multi), 0);
    endtask

    task automatic t_fill_hit();
        fill(7'd53, 2'd2, 20'h20035);
        lookup(32'h200356A4);
        expect_result("R6 R4 hit way2", 1'b1, 4'b0100, 1'b0);
        lookup(mk(20'h20035, 7'd53, 5'd31));
        expect_result("R4 other offset", 1'b1, 4'b0100, 1'b0);
    endtask

    task automatic t_miss();
        lookup(mk(20'h20036, 7'd53, 5'd0));
        expect_result("R5 tag differs", 1'b0, 4'b0000, 1'b0);
        lookup(mk(20'h20035, 7'd54, 5'd0));
        expect_result("R9 R5 other set", 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_all_ways();
        fill(7'd53, 2'd0, 20'h11111);
        fill(7'd53, 2'd1, 20'h22222);
        fill(7'd53, 2'd3, 20'h33333);
        lookup(mk(20'h11111, 7'd53, 5'd0));
        expect_result("R4 way0", 1'b1, 4'b0001, 1'b0);
        lookup(mk(20'h22222, 7'd53, 5'd0));
        expect_result("R4 way1", 1'b1, 4'b0010, 1'b0);
        lookup(mk(20'h33333, 7'd53, 5'd0));
        expect_result("R4 way3", 1'b1, 4'b1000, 1'b0);
        lookup(32'h200356A4);
        expect_result("R9 way2 kept", 1'b1, 4'b0100, 1'b0);
    endtask

    task automatic t_overwrite();
        fill(7'd53, 2'd1, 20'h44444);
        lookup(mk(20'h22222, 7'd53, 5'd0));
        expect_result("R6 old tag gone", 1'b0, 4'b0000, 1'b0);
        lookup(mk(20'h44444, 7'd53, 5'd0));
        expect_result("R6 new tag", 1'b1, 4'b0010, 1'b0);
    endtask

    task automatic t_same_cycle();
        fill_en = 1'b1; fill_set = 7'd10; fill_way = 2'd0; fill_tag = 20'hABCDE;
        lk_valid = 1'b1; lk_addr = mk(20'hABCDE, 7'd10, 5'd3);
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0; lk_valid = 1'b0;
        expect_result("R7 sees old contents", 1'b0, 4'b0000, 1'b0);
        lookup(mk(20'hABCDE, 7'd10, 5'd3));
        expect_result("R7 next lookup sees fill", 1'b1, 4'b0001, 1'b0);
    endtask

    task automatic t_multi();
        fill(7'd20, 2'd0, 20'h0F0F0);
        fill(7'd20, 2'd3, 20'h0F0F0);
        lookup(mk(20'h0F0F0, 7'd20, 5'd0));
        expect_result("R8 duplicate tags", 1'b0, 4'b0000, 1'b1);
        @(negedge clk);
        chk("R10 multi low idle", 32'(rsp_multi), 0);
    endtask

    task automatic t_reset_again();
        do_reset();
        lookup(32'h200356A4);
        expect_result("R1 reset clears valid", 1'b0, 4'b0000, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        lk_valid = 0; lk_addr = 0; fill_en = 0; fill_set = 0; fill_way = 0; fill_tag = 0;
        rst_n = 0;
        @(negedge clk);
        do_reset();
        t_reset_state();
        t_decode();
        t_latency();
        t_fill_hit();
        t_miss();
        t_all_ways();
        t_overwrite();
        t_same_cycle();
        t_multi();
        t_reset_again();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule